// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit general registers of a processor that runs in several privilege and exception modes. A 5-bit mode input chooses which physical copy each register number reaches. Two read ports are combinational and one write port is synchronous. All three are addressed by register number and resolved through the current mode. Alongside the general registers sit five saved-status registers, one per exception mode, reached through a single read/write port that is also resolved by the mode.

The surrounding core drives the mode from its status word and reads and writes operands by architectural number. The block does the bank selection, so that a mode change takes effect on the very next access with no copying of registers. A soft-reset input loads a fixed set of stack-pointer start values. An error output flags a mode value that has no defined bank.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears every physical general register and every saved-status register to zero.
- R2: Registers 0 to 7 and register 15 have a single physical copy, reached identically from every legal mode.
- R3: In fast-interrupt mode (mode 0x11), registers 8 to 14 reach a private bank of seven registers that no other mode reaches.
- R4: In interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) modes, registers 13 and 14 reach a private pair for that mode, while registers 8 to 12 reach the user copies.
- R5: User mode (0x10) and system mode (0x1F) reach the same physical registers, and for numbers 8 to 14 these are the user copies.
- R6: When `wr_en` is high in a legal mode, `wr_data` is stored at the next rising clock edge. A read of the same physical register in that cycle returns the old value.
- R7: Each of the five exception modes has its own saved-status register. `sr_rd_data` shows the copy for the current mode combinationally, and `sr_wr_en` writes it at the next rising edge.
- R8: In user or system mode, `sr_rd_data` is zero and `sr_wr_en` changes no saved-status register.
- R9: Any mode value other than 0x10, 0x11, 0x12, 0x13, 0x17, 0x1B and 0x1F drives `mode_err` high. In that state both read ports return zero, and general and saved-status writes are suppressed.
- R10: `soft_rst` (with `rst` low) sets user r13 to 0x03007F00, interrupt-mode r13 to 0x03007FA0 and supervisor-mode r13 to 0x03007FE0. It clears every other register, including the saved-status registers. It takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears all storage |
| soft_rst | input | 1 | Synchronous soft reset loading the stack-pointer start values |
| mode | input | 5 | Current processor mode code |
| ra_idx | input | 4 | Register number for read port A |
| ra_data | output | DATA_W | Read data, port A |
| rb_idx | input | 4 | Register number for read port B |
| rb_data | output | DATA_W | Read data, port B |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Register number for the write port |
| wr_data | input | DATA_W | Write data |
| sr_wr_en | input | 1 | Saved-status write enable |
| sr_wr_data | input | DATA_W | Saved-status write data |
| sr_rd_data | output | DATA_W | Saved-status read data for the current mode |
| mode_err | output | 1 | High while the mode code is not a legal one |

## Verification
Every legal mode writes a distinct value to every register number, and then every register is read back from every mode. A wrong bank map shows up as one mode's value appearing in another mode. The likely faults are r8 to r12 banked in the interrupt-class modes, r13 shared by fast-interrupt and user mode, and system mode given a bank of its own. All 32 mode codes are swept through the error output. Writes issued under an illegal code are followed by a full readback, which catches a design that still stores them. The bench also aims at three more faults: a read that forwards the value being written in the same cycle, a saved-status write that lands in some slot while in user mode, and a soft reset that loses to a simultaneous write or misplaces a stack value.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

    localparam int MODE_W  = 5;
    localparam int RIDX_W  = 4;
    localparam int NREG    = 16;
    localparam int NFIQ    = 7;
    localparam int NPAIRS  = 4;
    localparam int NPHYS   = NREG + NFIQ + 2 * NPAIRS;
    localparam int PIDX_W  = $clog2(NPHYS);
    localparam int NSR     = 5;
    localparam int SLOT_W  = $clog2(NSR);

    localparam logic [PIDX_W-1:0] FIQ_BASE  = PIDX_W'(NREG);
    localparam logic [PIDX_W-1:0] PAIR_BASE = PIDX_W'(NREG + NFIQ);

    typedef enum logic [MODE_W-1:0] {
        MD_USR = 5'h10,
        MD_FIQ = 5'h11,
        MD_IRQ = 5'h12,
        MD_SVC = 5'h13,
        MD_ABT = 5'h17,
        MD_UND = 5'h1B,
        MD_SYS = 5'h1F
    } mode_e;

    typedef struct packed {
        logic              legal;
        logic              has_sr;
        logic [SLOT_W-1:0] sr_slot;
        logic              fiq;
        logic [1:0]        pair;
    } mode_info_t;

    function automatic mode_info_t decode_mode(logic [MODE_W-1:0] m);
        mode_info_t mi;
        mi = '0;
        case (m)
            MD_USR, MD_SYS: mi.legal = 1'b1;
            MD_FIQ: begin mi.legal = 1'b1; mi.has_sr = 1'b1; mi.sr_slot = 3'd0; mi.fiq = 1'b1; end
            MD_IRQ: begin mi.legal = 1'b1; mi.has_sr = 1'b1; mi.sr_slot = 3'd1; mi.pair = 2'd0; end
            MD_SVC: begin mi.legal = 1'b1; mi.has_sr = 1'b1; mi.sr_slot = 3'd2; mi.pair = 2'd1; end
            MD_ABT: begin mi.legal = 1'b1; mi.has_sr = 1'b1; mi.sr_slot = 3'd3; mi.pair = 2'd2; end
            MD_UND: begin mi.legal = 1'b1; mi.has_sr = 1'b1; mi.sr_slot = 3'd4; mi.pair = 2'd3; end
            default: mi = '0;
        endcase
        return mi;
    endfunction

    function automatic logic [PIDX_W-1:0] phys_of(mode_info_t mi, logic [RIDX_W-1:0] r);
        logic [PIDX_W-1:0] r_ext;
        r_ext = {1'b0, r};
        if (mi.fiq && r >= 4'd8 && r <= 4'd14)
            return FIQ_BASE + r_ext - 5'd8;
        else if (mi.has_sr && !mi.fiq && (r == 4'd13 || r == 4'd14))
            return PAIR_BASE + {2'b00, mi.pair, 1'b0} + r_ext - 5'd13;
        else
            return r_ext;
    endfunction

    function automatic logic [31:0] soft_value(logic [PIDX_W-1:0] p);
        case (p)
            5'd13:            return 32'h0300_7F00;
            PAIR_BASE:        return 32'h0300_7FA0;
            PAIR_BASE + 5'd2: return 32'h0300_7FE0;
            default:          return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/rbank_mode_dec.sv
module rbank_mode_dec
    import rbank_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_info_t        info,
    output logic              err
);
    always_comb begin
        info = decode_mode(mode);
        err  = !info.legal;
    end
endmodule

// File: rtl/rbank_port_map.sv
module rbank_port_map
    import rbank_pkg::*;
#(
    parameter int NPORT = 3
) (
    input  mode_info_t                    info,
    input  logic [NPORT-1:0][RIDX_W-1:0]  idx,
    output logic [NPORT-1:0][PIDX_W-1:0]  phys
);
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        always_comb phys[g] = phys_of(info, idx[g]);
    end
endmodule

// File: rtl/rbank_gpr_store.sv
module rbank_gpr_store
    import rbank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NRD    = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           soft_rst,
    input  logic                           we,
    input  logic [PIDX_W-1:0]              wphys,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [NRD-1:0][PIDX_W-1:0]     rphys,
    output logic [NRD-1:0][DATA_W-1:0]     rdata,
    output logic [NPHYS-1:0][DATA_W-1:0]   image
);
    logic [NPHYS-1:0][DATA_W-1:0] cells;

    always_ff @(posedge clk) begin
        if (rst) begin
            cells <= '0;
        end else if (soft_rst) begin
            for (int i = 0; i < NPHYS; i++)
                cells[i] <= DATA_W'(soft_value(PIDX_W'(i)));
        end else if (we) begin
            cells[wphys] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        always_comb rdata[g] = cells[rphys[g]];
    end

    assign image = cells;
endmodule

// File: rtl/rbank_sr_store.sv
module rbank_sr_store
    import rbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         soft_rst,
    input  mode_info_t                   info,
    input  logic                         we,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [NSR-1:0][DATA_W-1:0]   image
);
    logic [NSR-1:0][DATA_W-1:0] slots;
    logic                       active;

    assign active = info.legal && info.has_sr;

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            slots <= '0;
        else if (we && active)
            slots[info.sr_slot] <= wdata;
    end

    always_comb rdata = active ? slots[info.sr_slot] : '0;

    assign image = slots;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic [4:0]        mode,
    input  logic [3:0]        ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [3:0]        rb_idx,
    output logic [DATA_W-1:0] rb_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sr_wr_en,
    input  logic [DATA_W-1:0] sr_wr_data,
    output logic [DATA_W-1:0] sr_rd_data,
    output logic              mode_err
);
    localparam int NRD = 2;

    mode_info_t                    info;
    logic [NRD:0][RIDX_W-1:0]      port_idx;
    logic [NRD:0][PIDX_W-1:0]      port_phys;
    logic [NRD-1:0][DATA_W-1:0]    raw_rd;
    logic [NPHYS-1:0][DATA_W-1:0]  gpr_image;
    logic [NSR-1:0][DATA_W-1:0]    sr_image;
    logic                          gpr_we;

    rbank_mode_dec u_dec (
        .mode (mode),
        .info (info),
        .err  (mode_err)
    );

    assign port_idx = {wr_idx, rb_idx, ra_idx};

    rbank_port_map #(.NPORT(NRD + 1)) u_map (
        .info (info),
        .idx  (port_idx),
        .phys (port_phys)
    );

    assign gpr_we = wr_en && info.legal;

    rbank_gpr_store #(.DATA_W(DATA_W), .NRD(NRD)) u_gpr (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .we       (gpr_we),
        .wphys    (port_phys[NRD]),
        .wdata    (wr_data),
        .rphys    (port_phys[NRD-1:0]),
        .rdata    (raw_rd),
        .image    (gpr_image)
    );

    rbank_sr_store #(.DATA_W(DATA_W)) u_sr (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .info     (info),
        .we       (sr_wr_en),
        .wdata    (sr_wr_data),
        .rdata    (sr_rd_data),
        .image    (sr_image)
    );

    assign ra_data = info.legal ? raw_rd[0] : '0;
    assign rb_data = info.legal ? raw_rd[1] : '0;
endmodule

// File: rtl/rbank_checker.sv
module rbank_checker
    import rbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          soft_rst,
    input  logic [4:0]                    mode,
    input  logic [3:0]                    ra_idx,
    input  logic [DATA_W-1:0]             ra_data,
    input  logic                          wr_en,
    input  logic [3:0]                    wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [DATA_W-1:0]             sr_rd_data,
    input  logic                          mode_err,
    input  logic [NPHYS-1:0][DATA_W-1:0]  gpr_image,
    input  logic [NSR-1:0][DATA_W-1:0]    sr_image
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (gpr_image == '0 && sr_image == '0));

    p_low_shared_r2: assert property (@(posedge clk) disable iff (rst)
        (!mode_err && (ra_idx < 4'd8 || ra_idx == 4'd15)) |-> ra_data == gpr_image[ra_idx]);

    p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mode_err && !soft_rst && wr_idx < 4'd8)
        |=> gpr_image[$past(wr_idx)] == $past(wr_data));

    p_usr_sr_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == 5'h10 || mode == 5'h1F) |-> sr_rd_data == '0);

    p_err_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> ra_data == '0);

    p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_err && !soft_rst) |=> ($stable(gpr_image) && $stable(sr_image)));

    p_soft_vals_r10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (gpr_image[13] == DATA_W'(32'h0300_7F00)
                   && gpr_image[PAIR_BASE] == DATA_W'(32'h0300_7FA0)
                   && gpr_image[PAIR_BASE + 5'd2] == DATA_W'(32'h0300_7FE0)
                   && gpr_image[0] == '0 && sr_image == '0));
endmodule

bind banked_regfile rbank_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .mode       (mode),
    .ra_idx     (ra_idx),
    .ra_data    (ra_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .sr_rd_data (sr_rd_data),
    .mode_err   (mode_err),
    .gpr_image  (gpr_image),
    .sr_image   (sr_image)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic [4:0]  mode = 5'h10;
    logic [3:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
    logic [31:0] ra_data, rb_data, wr_data = '0, sr_wr_data = '0, sr_rd_data;
    logic        wr_en = 1'b0, sr_wr_en = 1'b0, mode_err;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    banked_regfile u_banked_regfile (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .mode(mode),
        .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data),
        .mode_err(mode_err)
    );

    // reference model: user set, fast bank r8..r14, four r13/r14 pairs, five status slots
    logic [31:0] m_usr [16];
    logic [31:0] m_fiq [7];
    logic [31:0] m_pair [4][2];
    logic [31:0] m_sr [5];

    logic [4:0] legal_modes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};

    function automatic int pair_of(logic [4:0] m);
        case (m)
            5'h12: return 0;
            5'h13: return 1;
            5'h17: return 2;
            5'h1B: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic int slot_of(logic [4:0] m);
        if (m == 5'h11) return 0;
        if (pair_of(m) >= 0) return pair_of(m) + 1;
        return -1;
    endfunction

    function automatic logic is_legal(logic [4:0] m);
        foreach (legal_modes[k]) if (legal_modes[k] == m) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_rd(logic [4:0] m, int r);
        if (!is_legal(m)) return 32'h0;
        if (m == 5'h11 && r >= 8 && r <= 14) return m_fiq[r-8];
        if (pair_of(m) >= 0 && r >= 13 && r <= 14) return m_pair[pair_of(m)][r-13];
        return m_usr[r];
    endfunction

    function automatic string tag_for(logic [4:0] m, int r);
        if (r < 8 || r == 15) return "R2";
        if (m == 5'h11) return "R3";
        if (m == 5'h10 || m == 5'h1F) return "R5";
        return "R4";
    endfunction

    task automatic model_clear();
        foreach (m_usr[i]) m_usr[i] = '0;
        foreach (m_fiq[i]) m_fiq[i] = '0;
        foreach (m_pair[i, j]) m_pair[i][j] = '0;
        foreach (m_sr[i]) m_sr[i] = '0;
    endtask

    task automatic model_write(logic [4:0] m, int r, logic [31:0] v);
        if (!is_legal(m)) return;
        if (m == 5'h11 && r >= 8 && r <= 14) m_fiq[r-8] = v;
        else if (pair_of(m) >= 0 && r >= 13 && r <= 14) m_pair[pair_of(m)][r-13] = v;
        else m_usr[r] = v;
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_write(logic [4:0] m, int r, logic [31:0] v);
        @(negedge clk);
        mode = m; wr_idx = 4'(r); wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(m, r, v);
    endtask

    task automatic rd_check(logic [4:0] m, int r);
        @(negedge clk);
        mode = m; ra_idx = 4'(r); rb_idx = 4'(15 - r);
        #1;
        chk(tag_for(m, r), $sformatf("mode %h port A r%0d", m, r), ra_data, exp_rd(m, r));
        chk(tag_for(m, 15 - r), $sformatf("mode %h port B r%0d", m, 15 - r), rb_data, exp_rd(m, 15 - r));
    endtask

    task automatic sweep_all(string tag);
        foreach (legal_modes[k])
            for (int r = 0; r < 16; r++) begin
                @(negedge clk);
                mode = legal_modes[k]; ra_idx = 4'(r); rb_idx = 4'(15 - r);
                #1;
                chk(tag, $sformatf("sweep mode %h r%0d A", mode, r), ra_data, exp_rd(mode, r));
                chk(tag, $sformatf("sweep mode %h r%0d B", mode, 15 - r), rb_data, exp_rd(mode, 15 - r));
            end
        foreach (legal_modes[k])
            if (slot_of(legal_modes[k]) >= 0) begin
                @(negedge clk);
                mode = legal_modes[k];
                #1;
                chk(tag, $sformatf("status mode %h", mode), sr_rd_data, m_sr[slot_of(mode)]);
            end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", total);
        summary();
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: everything reads zero after reset
        sweep_all("R1");

        // R9: error output across every mode code
        for (int c = 0; c < 32; c++) begin
            @(negedge clk);
            mode = 5'(c);
            #1;
            chk("R9", $sformatf("mode_err for code %h", c), 32'(mode_err), 32'(!is_legal(5'(c))));
        end

        // R2..R5: distinct value per mode and register, then full readback
        foreach (legal_modes[k])
            for (int r = 0; r < 16; r++)
                do_write(legal_modes[k], r, 32'hA000_0000 | (32'(legal_modes[k]) << 16) | (32'(r) << 8) | 32'h5A);
        foreach (legal_modes[k])
            for (int r = 0; r < 16; r++)
                rd_check(legal_modes[k], r);

        // R5: a system-mode write is seen from user mode
        do_write(5'h1F, 9, 32'h5555_1F09);
        rd_check(5'h10, 9);

        // R6: same-cycle read sees old value, new value after the edge
        @(negedge clk);
        mode = 5'h12; ra_idx = 4'd13; wr_idx = 4'd13; wr_data = 32'hC011_1DE0; wr_en = 1'b1;
        #1;
        chk("R6", "collision read before edge", ra_data, exp_rd(5'h12, 13));
        @(negedge clk);
        wr_en = 1'b0;
        model_write(5'h12, 13, 32'hC011_1DE0);
        #1;
        chk("R6", "collision read after edge", ra_data, 32'hC011_1DE0);

        // R7: each exception mode writes its own status slot
        foreach (legal_modes[k])
            if (slot_of(legal_modes[k]) >= 0) begin
                @(negedge clk);
                mode = legal_modes[k]; sr_wr_data = 32'h5700_0000 | 32'(legal_modes[k]); sr_wr_en = 1'b1;
                @(negedge clk);
                sr_wr_en = 1'b0;
                m_sr[slot_of(legal_modes[k])] = 32'h5700_0000 | 32'(legal_modes[k]);
            end
        sweep_all("R7");

        // R8: user/system status access reads zero and writes nothing
        for (int u = 0; u < 2; u++) begin
            @(negedge clk);
            mode = (u == 0) ? 5'h10 : 5'h1F; sr_wr_data = 32'hDEAD_BEEF; sr_wr_en = 1'b1;
            #1;
            chk("R8", "status read in user/system", sr_rd_data, 32'h0);
            @(negedge clk);
            sr_wr_en = 1'b0;
            #1;
            chk("R8", "status read after write attempt", sr_rd_data, 32'h0);
        end
        foreach (legal_modes[k])
            if (slot_of(legal_modes[k]) >= 0) begin
                @(negedge clk);
                mode = legal_modes[k];
                #1;
                chk("R8", $sformatf("slot untouched mode %h", mode), sr_rd_data, m_sr[slot_of(mode)]);
            end

        // R9: illegal codes read zero and suppress writes
        for (int c = 0; c < 32; c++) begin
            if (is_legal(5'(c))) continue;
            @(negedge clk);
            mode = 5'(c); ra_idx = 4'(c % 16); rb_idx = 4'd13;
            wr_idx = 4'(c % 16); wr_data = 32'hBAD0_0000 | 32'(c); wr_en = 1'b1;
            sr_wr_data = 32'hBAD1_0000; sr_wr_en = 1'b1;
            #1;
            chk("R9", $sformatf("illegal %h port A", c), ra_data, 32'h0);
            chk("R9", $sformatf("illegal %h port B", c), rb_data, 32'h0);
            @(negedge clk);
            wr_en = 1'b0; sr_wr_en = 1'b0;
        end
        sweep_all("R9");

        // R10: soft reset, colliding with a write to r0
        @(negedge clk);
        mode = 5'h10; soft_rst = 1'b1; wr_idx = 4'd0; wr_data = 32'h1234_5678; wr_en = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0; wr_en = 1'b0;
        model_clear();
        m_usr[13] = 32'h0300_7F00;
        m_pair[0][0] = 32'h0300_7FA0;
        m_pair[1][0] = 32'h0300_7FE0;
        sweep_all("R10");

        // R1: hard reset after data is present
        do_write(5'h11, 10, 32'hFFFF_0010);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        sweep_all("R1");

        summary();
        $finish;
    end
endmodule